// File: doc/BRIEF.md
# Branching Program Counter

This block holds the fetch address of a small processor and picks, on every rising clock edge, where the next instruction comes from. There are three sources. The first is an absolute jump target taken straight from the immediate input. The second is a PC-relative target, the current address plus the immediate, used when a conditional branch is taken. The third is the plain sequential successor. All address arithmetic wraps modulo the address range.

Conditional branches are qualified by a zero flag that an arithmetic unit has already stored. A branch-if-not-equal is taken when the flag is low. A branch-if-equal is taken when the flag is high. A conditional branch that is not taken simply advances to the next address. The absolute jump request outranks both conditional requests.

The reset input is active low and acts asynchronously. The counter clears the moment reset falls and stays at zero until reset is released.

Top module: `branch_pc`

## Requirements
- R1: When `rst_n` falls, `pc_q` becomes 0 at once, without waiting for a clock edge.
- R2: While `rst_n` is low, `pc_q` stays at 0 through clock edges, whatever the other inputs do.
- R3: When `jump_abs` is 1 at a rising edge, `pc_q` takes the value of `imm` after that edge.
- R4: When `br_ne` is 1, `jump_abs` is 0 and `zflag` is 0 at a rising edge, `pc_q` becomes the old `pc_q` plus `imm`.
- R5: When `br_eq` is 1, `jump_abs` is 0 and `zflag` is 1 at a rising edge, `pc_q` becomes the old `pc_q` plus `imm`.
- R6: When none of `jump_abs`, `br_ne` and `br_eq` is set, `pc_q` becomes the old `pc_q` plus 1, so 255 is followed by 0.
- R7: The relative addition of R4 and R5 is taken modulo 256; for example, 200 plus 100 gives 44.
- R8: When `jump_abs` is set together with `br_ne` or `br_eq`, the absolute load of R3 wins even if a conditional branch would be taken.
- R9: A conditional request whose condition is false acts as a sequential step to the old `pc_q` plus 1. This covers `br_ne` with `zflag` 1, and `br_eq` with `zflag` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous clear |
| jump_abs | input | 1 | Unconditional jump to the absolute address `imm` |
| br_ne | input | 1 | Relative branch, taken when `zflag` is 0 |
| br_eq | input | 1 | Relative branch, taken when `zflag` is 1 |
| zflag | input | 1 | Stored zero flag from the arithmetic unit |
| imm | input | 8 | Jump target or relative offset, zero-extended |
| pc_q | output | 8 | Current program address |

## Verification
The hardest situations to reach are the ones at the edges of the address range. One is a relative branch whose sum carries past 255. Another is a sequential step out of 255. A third is the reset falling between two clock edges while the counter holds a nonzero value. Random stimulus seldom lands on these. The bench therefore first drives an absolute jump to a chosen address near the top of the range, then a taken branch with a large offset or a plain step. It also drops reset in the middle of a clock phase and checks the output before the next edge arrives. Random flag mixes are used to cover the priority order and the not-taken cases.

// File: rtl/pc_pkg.sv
package pc_pkg;

   typedef enum logic [1:0] {
      NXT_SEQ = 2'd0,
      NXT_ABS = 2'd1,
      NXT_REL = 2'd2
   } nxt_sel_e;

endpackage

// File: rtl/pc_sel_dec.sv
module pc_sel_dec
   import pc_pkg::*;
(
   input  logic     jump_abs,
   input  logic     br_ne,
   input  logic     br_eq,
   input  logic     zflag,
   output nxt_sel_e sel
);

   logic ne_hit;
   logic eq_hit;

   assign ne_hit = br_ne & ~zflag;
   assign eq_hit = br_eq & zflag;

   always_comb begin
      if (jump_abs)
         sel = NXT_ABS;
      else if (ne_hit || eq_hit)
         sel = NXT_REL;
      else
         sel = NXT_SEQ;
   end

endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
   import pc_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int IMM_W      = 8,
   parameter int STEP       = 1,
   parameter bit REL_SIGNED = 1'b0
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [IMM_W-1:0]  imm,
   input  nxt_sel_e          sel,
   output logic [ADDR_W-1:0] nxt
);

   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   logic [ADDR_W-1:0] imm_abs;
   logic [ADDR_W-1:0] imm_off;
   logic [ADDR_W-1:0] seq_addr;
   logic [ADDR_W-1:0] rel_addr;

   assign imm_abs = ADDR_W'(imm);

   generate
      if (REL_SIGNED) begin : g_off_signed
         assign imm_off = ADDR_W'($signed(imm));
      end else begin : g_off_unsigned
         assign imm_off = ADDR_W'(imm);
      end
   endgenerate

   assign seq_addr = cur + STEP_V;
   assign rel_addr = cur + imm_off;

   always_comb begin
      unique case (sel)
         NXT_ABS: nxt = imm_abs;
         NXT_REL: nxt = rel_addr;
         default: nxt = seq_addr;
      endcase
   end

endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg #(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RESET_VAL;
      else
         q <= d;
   end

endmodule

// File: rtl/branch_pc.sv
module branch_pc
   import pc_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int IMM_W      = 8,
   parameter int STEP       = 1,
   parameter bit REL_SIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              jump_abs,
   input  logic              br_ne,
   input  logic              br_eq,
   input  logic              zflag,
   input  logic [IMM_W-1:0]  imm,
   output logic [ADDR_W-1:0] pc_q
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr_w
         $error("branch_pc: ADDR_W out of range");
      end
      if (IMM_W < 1 || IMM_W > ADDR_W) begin : g_bad_imm_w
         $error("branch_pc: IMM_W must be 1..ADDR_W");
      end
      if (STEP < 1 || STEP >= ADDR_SPAN) begin : g_bad_step
         $error("branch_pc: STEP must be 1..2**ADDR_W-1");
      end
   endgenerate

   nxt_sel_e          sel;
   logic [ADDR_W-1:0] nxt;

   pc_sel_dec u_dec (
      .jump_abs (jump_abs),
      .br_ne    (br_ne),
      .br_eq    (br_eq),
      .zflag    (zflag),
      .sel      (sel)
   );

   pc_next_calc #(
      .ADDR_W     (ADDR_W),
      .IMM_W      (IMM_W),
      .STEP       (STEP),
      .REL_SIGNED (REL_SIGNED)
   ) u_calc (
      .cur (pc_q),
      .imm (imm),
      .sel (sel),
      .nxt (nxt)
   );

   pc_state_reg #(
      .ADDR_W    (ADDR_W),
      .RESET_VAL ('0)
   ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nxt),
      .q     (pc_q)
   );

endmodule

// File: rtl/branch_pc_chk.sv
module branch_pc_chk #(
   parameter int ADDR_W = 8,
   parameter int IMM_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              jump_abs,
   input logic              br_ne,
   input logic              br_eq,
   input logic              zflag,
   input logic [IMM_W-1:0]  imm,
   input logic [ADDR_W-1:0] pc_q
);

   // R1: the clear acts asynchronously; checked on the falling edge of rst_n
   always @(negedge rst_n) begin
      #1;
      if (!rst_n) p_async_clear_r1: assert (pc_q == '0);
   end

   p_hold_in_reset_r2: assert property (@(posedge clk)
      !rst_n |-> pc_q == '0);

   p_abs_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      jump_abs |=> pc_q == ADDR_W'($past(imm)));

   // R4 and R7: the relative sum wraps modulo the address range
   p_ne_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!jump_abs && br_ne && !zflag) |=> pc_q == $past(pc_q) + ADDR_W'($past(imm)));

   // R5 and R7
   p_eq_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!jump_abs && br_eq && zflag) |=> pc_q == $past(pc_q) + ADDR_W'($past(imm)));

   p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!jump_abs && !br_ne && !br_eq) |=> pc_q == $past(pc_q) + ADDR_W'(1));

   p_abs_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_abs && (br_ne || br_eq)) |=> pc_q == ADDR_W'($past(imm)));

   p_not_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!jump_abs && (br_ne || br_eq) && !(br_ne && !zflag) && !(br_eq && zflag))
      |=> pc_q == $past(pc_q) + ADDR_W'(1));

endmodule

bind branch_pc branch_pc_chk #(
   .ADDR_W (ADDR_W),
   .IMM_W  (IMM_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .jump_abs (jump_abs),
   .br_ne    (br_ne),
   .br_eq    (br_eq),
   .zflag    (zflag),
   .imm      (imm),
   .pc_q     (pc_q)
);

// File: tb/branch_pc_tb_top.sv
`timescale 1ns/1ps
module branch_pc_tb_top;

   logic       clk;
   logic       rst_n;
   logic       jump_abs;
   logic       br_ne;
   logic       br_eq;
   logic       zflag;
   logic [7:0] imm;
   logic [7:0] pc_q;

   int   n_checks;
   int   n_errors;
   bit   done;
   logic [7:0] exp_pc;

   branch_pc dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .jump_abs (jump_abs),
      .br_ne    (br_ne),
      .br_eq    (br_eq),
      .zflag    (zflag),
      .imm      (imm),
      .pc_q     (pc_q)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   function automatic logic [7:0] model_next(input logic [7:0] cur,
                                             input logic a, input logic ne,
                                             input logic eq, input logic z,
                                             input logic [7:0] im);
      if (a) return im;
      if ((ne && !z) || (eq && z)) return cur + im;
      return cur + 8'd1;
   endfunction

   function automatic string req_of(input logic a, input logic ne,
                                    input logic eq, input logic z);
      if (a && (ne || eq)) return "R8";
      if (a) return "R3";
      if (ne && !z) return "R4";
      if (eq && z) return "R5";
      if (ne || eq) return "R9";
      return "R6";
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: pc_q actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive at the falling edge, let one rising edge pass, compare at the next falling edge
   task automatic step(input logic a, input logic ne, input logic eq,
                       input logic z, input logic [7:0] im, input string req);
      jump_abs = a; br_ne = ne; br_eq = eq; zflag = z; imm = im;
      exp_pc = model_next(exp_pc, a, ne, eq, z, im);
      @(negedge clk);
      check(req, pc_q, exp_pc);
   endtask

   initial begin : watchdog
      #(1_000_000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : main
      int seed;
      seed = $urandom(32'h5eed_0042);
      n_checks = 0; n_errors = 0; done = 1'b0;
      rst_n = 1'b1; jump_abs = 0; br_ne = 0; br_eq = 0; zflag = 0; imm = '0;
      #2 rst_n = 1'b0;
      #1 check("R1", pc_q, 8'd0);
      // R2: flags active across edges while in reset
      jump_abs = 1; imm = 8'd77;
      @(negedge clk); @(negedge clk);
      check("R2", pc_q, 8'd0);
      jump_abs = 0; imm = 8'd0;
      rst_n = 1'b1;
      exp_pc = 8'd0;

      step(0, 0, 0, 0, 8'd0,   "R6");
      step(1, 0, 0, 0, 8'd250, "R3");
      // R6: sequential wrap from 255 to 0
      step(1, 0, 0, 0, 8'd255, "R3");
      step(0, 0, 0, 1, 8'd9,   "R6");
      check("R6", pc_q, 8'd0);
      // R7: relative wrap 200 + 100 = 44
      step(1, 0, 0, 0, 8'd200, "R3");
      step(0, 0, 1, 1, 8'd100, "R5");
      check("R7", pc_q, 8'd44);
      step(0, 1, 0, 0, 8'd230, "R4");
      check("R7", pc_q, 8'd18);
      // R8: absolute wins over taken conditionals
      step(1, 1, 1, 0, 8'd3,   "R8");
      step(1, 0, 1, 1, 8'd90,  "R8");
      check("R8", pc_q, 8'd90);
      // R9: not-taken conditionals
      step(0, 1, 0, 1, 8'd40,  "R9");
      step(0, 0, 1, 0, 8'd40,  "R9");
      check("R9", pc_q, 8'd92);
      // R4/R5: both conditionals set, one of them always holds
      step(0, 1, 1, 0, 8'd5,   "R4");
      step(0, 1, 1, 1, 8'd5,   "R5");

      // R1: clear between edges while nonzero
      step(1, 0, 0, 0, 8'd123, "R3");
      #2 rst_n = 1'b0;
      #1 check("R1", pc_q, 8'd0);
      @(negedge clk);
      check("R2", pc_q, 8'd0);
      rst_n = 1'b1;
      exp_pc = 8'd0;

      for (int i = 0; i < 400; i++) begin
         logic [3:0] r;
         logic [7:0] im;
         r  = 4'($urandom);
         im = 8'($urandom);
         step(r[0] & r[1] & r[2], r[1], r[2], r[3], im,
              req_of(r[0] & r[1] & r[2], r[1], r[2], r[3]));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule